// File: doc/BRIEF.md
# PHY PLL Disable Sequencer

This block runs the fixed power-down order for one display PHY port. A single start pulse begins the run. The block clears the lane pulse-status bits and puts the owned lanes into pipe reset. It then waits a bounded time for those lanes to report that they are in reset, and clears the pulse-status bits a second time. Next it withdraws the lane-0 PLL request and writes a zero valid-frequency value. It waits a bounded time for the PLL acknowledge to fall. Finally it gates the port clocks, asserts the MAC clock reset and reports done.

Each register write is a one-cycle strobe on its own output port. The logic that owns the real register fields applies the strobe. Lane ownership is sampled on the start pulse and decides whether the lane strobes and the reset-status check cover both lanes or lane 0 only. A wait that runs out does not stop the run. It sets a sticky flag and raises a warning, and the sequence continues to the end.

Top module: `pll_shutdown_fsm`

## Requirements
- R1: After reset, busy_o, done_o, every strobe output, both timeout flags and warn_o are 0.
- R2: A start_i sampled high while idle starts a run. busy_o is 1 from the next cycle up to and including the single cycle in which done_o is 1, and is 0 in the cycle after. No strobe is active while busy_o is 0.
- R3: Lane strobes use bit 0 for lane 0 and bit 1 for lane 1. If lane_own_i equals 2'b11 when a run starts, the lane strobes and the status check cover both lanes. Any other value covers lane 0 only, so the lane strobes read 2'b01.
- R4: Counting the cycle after the start edge as cycle 1, the strobes come one per cycle in this order: clr_pulse_o in cycle 1, pipe_rst_o in cycle 2, the reset wait from cycle 3, clr_pulse_o again, pll_req_clr_o, valfreq_zero_o, the acknowledge wait, clk_gate_o, macclk_rst_o, then done_o. Apart from the waits there are no gaps.
- R5: The reset wait ends in the first wait cycle in which every owned bit of cur_status_i is 1. The second status clear follows in the next cycle. A lane that is not owned has no effect on the wait.
- R6: The reset wait lasts at most CLK_MHZ*RST_WAIT_US cycles. If it runs out, rst_timeout_o goes to 1 and the sequence continues.
- R7: The acknowledge wait ends in the first wait cycle in which pll_ack_i is 0, and clk_gate_o follows in the next cycle. The wait lasts at most CLK_MHZ*ACK_WAIT_US cycles. If it runs out, ack_timeout_o goes to 1 and the sequence continues.
- R8: warn_o is 1 whenever either timeout flag is 1.
- R9: Both timeout flags hold their value after done and are cleared by the next accepted start.
- R10: A start_i sampled high while busy is ignored. It changes neither the timing nor the content of the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a teardown run |
| lane_own_i | input | 2 | Lane ownership mask; 2'b11 means both lanes |
| cur_status_i | input | 2 | Per-lane "in reset" status |
| pll_ack_i | input | 1 | Lane-0 PLL acknowledge |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| clr_pulse_o | output | 2 | Write-one-to-clear strobe for the lane pulse-status bits |
| pipe_rst_o | output | 2 | Set strobe for the lane pipe-reset bits |
| pll_req_clr_o | output | 1 | Clear strobe for the lane-0 PLL request |
| valfreq_zero_o | output | 1 | Strobe that writes 0 to the valid-frequency value |
| clk_gate_o | output | 1 | Strobe that clears the clock select and the forward-clock ungate |
| macclk_rst_o | output | 1 | Set strobe for the MAC clock reset |
| rst_timeout_o | output | 1 | Sticky: lane reset wait timed out |
| ack_timeout_o | output | 1 | Sticky: PLL acknowledge wait timed out |
| warn_o | output | 1 | Either timeout flag set |

## Verification
The assertions check several properties on every cycle. At most one action is active per cycle, and nothing is active while idle. Lane-1 strobes never appear without lane 0. The valid-frequency write always follows the request clear, and done always follows the MAC reset. A clock gate without an acknowledge timeout is always preceded by a low acknowledge, and the flags stay stable between runs. Other properties need the bench's scenarios: the exact cycle of every strobe, the full timeout lengths of both waits, a status that rises in the middle of a wait, ownership patterns other than 2'b11, and a start pulse that arrives mid-run.

// File: rtl/pll_shutdown_fsm.sv
module pll_shutdown_fsm #(
  parameter int CLK_MHZ     = 100,
  parameter int RST_WAIT_US = 10,
  parameter int ACK_WAIT_US = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] lane_own_i,
  input  logic [1:0] cur_status_i,
  input  logic       pll_ack_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] clr_pulse_o,
  output logic [1:0] pipe_rst_o,
  output logic       pll_req_clr_o,
  output logic       valfreq_zero_o,
  output logic       clk_gate_o,
  output logic       macclk_rst_o,
  output logic       rst_timeout_o,
  output logic       ack_timeout_o,
  output logic       warn_o
);
  localparam int RST_CYC = CLK_MHZ * RST_WAIT_US;
  localparam int ACK_CYC = CLK_MHZ * ACK_WAIT_US;
  localparam int MAX_CYC = (RST_CYC > ACK_CYC) ? RST_CYC : ACK_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CLR1, S_PRST, S_WRST, S_CLR2,
    S_REQ, S_VFQ, S_WACK, S_GATE, S_MRST, S_DONE
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [1:0]    lanes;

  wire lanes_ready = (cur_status_i & lanes) == lanes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      cnt           <= '0;
      lanes         <= 2'b00;
      rst_timeout_o <= 1'b0;
      ack_timeout_o <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          st            <= S_CLR1;
          lanes         <= (lane_own_i == 2'b11) ? 2'b11 : 2'b01;
          rst_timeout_o <= 1'b0;
          ack_timeout_o <= 1'b0;
        end
        S_CLR1: st <= S_PRST;
        S_PRST: begin
          st  <= S_WRST;
          cnt <= '0;
        end
        S_WRST:
          if (lanes_ready) st <= S_CLR2;
          else if (cnt == CW'(RST_CYC - 1)) begin
            rst_timeout_o <= 1'b1;
            st            <= S_CLR2;
          end else cnt <= cnt + 1'b1;
        S_CLR2: st <= S_REQ;
        S_REQ:  st <= S_VFQ;
        S_VFQ: begin
          st  <= S_WACK;
          cnt <= '0;
        end
        S_WACK:
          if (!pll_ack_i) st <= S_GATE;
          else if (cnt == CW'(ACK_CYC - 1)) begin
            ack_timeout_o <= 1'b1;
            st            <= S_GATE;
          end else cnt <= cnt + 1'b1;
        S_GATE: st <= S_MRST;
        S_MRST: st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy_o         = st != S_IDLE;
  assign done_o         = st == S_DONE;
  assign clr_pulse_o    = (st == S_CLR1 || st == S_CLR2) ? lanes : 2'b00;
  assign pipe_rst_o     = (st == S_PRST) ? lanes : 2'b00;
  assign pll_req_clr_o  = st == S_REQ;
  assign valfreq_zero_o = st == S_VFQ;
  assign clk_gate_o     = st == S_GATE;
  assign macclk_rst_o   = st == S_MRST;
  assign warn_o         = rst_timeout_o | ack_timeout_o;
endmodule

// File: rtl/pll_shutdown_fsm_chk.sv
module pll_shutdown_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       pll_ack_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] clr_pulse_o,
  input logic [1:0] pipe_rst_o,
  input logic       pll_req_clr_o,
  input logic       valfreq_zero_o,
  input logic       clk_gate_o,
  input logic       macclk_rst_o,
  input logic       rst_timeout_o,
  input logic       ack_timeout_o
);
  wire any_act = |clr_pulse_o | |pipe_rst_o | pll_req_clr_o | valfreq_zero_o |
                 clk_gate_o | macclk_rst_o | done_o;

  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R2
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !any_act); // R2
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|clr_pulse_o, |pipe_rst_o, pll_req_clr_o, valfreq_zero_o,
              clk_gate_o, macclk_rst_o, done_o})); // R4
  AST_LANE1_WITH_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_rst_o[1] | clr_pulse_o[1]) |-> (pipe_rst_o[0] | clr_pulse_o[0])); // R3
  AST_VF_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    valfreq_zero_o |-> $past(pll_req_clr_o)); // R4
  AST_MAC_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(macclk_rst_o)); // R4
  AST_GATE_AFTER_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_gate_o && !ack_timeout_o) |-> $past(!pll_ack_i)); // R7
  AST_FLAGS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> ($stable(rst_timeout_o) && $stable(ack_timeout_o))); // R9
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && start_i) |=> busy_o); // R10
endmodule

bind pll_shutdown_fsm pll_shutdown_fsm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .pll_ack_i(pll_ack_i),
  .busy_o(busy_o), .done_o(done_o), .clr_pulse_o(clr_pulse_o),
  .pipe_rst_o(pipe_rst_o), .pll_req_clr_o(pll_req_clr_o),
  .valfreq_zero_o(valfreq_zero_o), .clk_gate_o(clk_gate_o),
  .macclk_rst_o(macclk_rst_o), .rst_timeout_o(rst_timeout_o),
  .ack_timeout_o(ack_timeout_o)
);

// File: tb/pll_shutdown_fsm_bench.sv
module pll_shutdown_fsm_bench;
  localparam int L_RST = 10 * 100;
  localparam int L_ACK = 1 * 100;

  logic clk = 0, rst_n = 0, start = 0, pll_ack = 0;
  logic [1:0] own = 2'b11, cur = 2'b00;
  logic busy, done, req_clr, vf_zero, gate, mac_rst, rst_to, ack_to, warn;
  logic [1:0] clr, prst;

  always #5 clk = ~clk;

  pll_shutdown_fsm u_pll_shutdown_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start), .lane_own_i(own),
    .cur_status_i(cur), .pll_ack_i(pll_ack), .busy_o(busy), .done_o(done),
    .clr_pulse_o(clr), .pipe_rst_o(prst), .pll_req_clr_o(req_clr),
    .valfreq_zero_o(vf_zero), .clk_gate_o(gate), .macclk_rst_o(mac_rst),
    .rst_timeout_o(rst_to), .ack_timeout_o(ack_to), .warn_o(warn)
  );

  typedef struct { int code; int val; int at; string req; } item_t;
  item_t exp_q[$];
  int n_chk = 0, n_fail = 0, rel = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(posedge clk) rel <= (start && !busy) ? 1 : rel + 1;

  // monitor: codes 1 clr, 2 pipe reset, 3 req clr, 4 valfreq, 5 gate, 6 mac reset, 7 done
  always @(negedge clk) if (rst_n) begin
    int code, val;
    code = 0; val = 0;
    if (|clr)        begin code = 1; val = clr; end
    else if (|prst)  begin code = 2; val = prst; end
    else if (req_clr) code = 3;
    else if (vf_zero) code = 4;
    else if (gate)    code = 5;
    else if (mac_rst) code = 6;
    else if (done)   begin code = 7; val = {warn, ack_to, rst_to}; end
    if (code != 0) begin
      if (exp_q.size() == 0) check(0, "R2 unexpected action", code, 0);
      else begin
        item_t e;
        e = exp_q.pop_front();
        check(code == e.code, {e.req, " action code"}, code, e.code);
        check(val == e.val, {e.req, " value"}, val, e.val);
        check(rel == e.at, {e.req, " cycle"}, rel, e.at);
        if (code == 7) check(busy == 1'b1, "R2 busy with done", busy, 1);
      end
    end
  end

  task automatic push(input int code, input int val, input int at, input string req);
    item_t e;
    e.code = code; e.val = val; e.at = at; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic run(input logic [1:0] o, input logic [1:0] s0, input int s_at,
                     input logic a0, input int a_at, input bit extra);
    int ln, c, g, f1, f2;
    ln = (o == 2'b11) ? 3 : 1;
    f1 = 0; f2 = 0;
    if ((s0 & ln[1:0]) == ln[1:0]) c = 4;
    else if (s_at >= 3 && s_at < 3 + L_RST) c = s_at + 1;
    else begin c = 3 + L_RST; f1 = 1; end
    if (!a0) g = c + 4;
    else if (a_at >= c + 3 && a_at < c + 3 + L_ACK) g = a_at + 1;
    else begin g = c + 3 + L_ACK; f2 = 1; end
    push(1, ln, 1, "R3/R4 first clear");
    push(2, ln, 2, "R3/R4 pipe reset");
    push(1, ln, c, f1 ? "R6 clear after timeout" : "R5 clear after ready");
    push(3, 0, c + 1, "R4 request clear");
    push(4, 0, c + 2, "R4 valfreq zero");
    push(5, 0, g, f2 ? "R7 gate after timeout" : "R7 gate after ack low");
    push(6, 0, g + 1, "R4 mac reset");
    push(7, ((f1 | f2) << 2) | (f2 << 1) | f1, g + 2, "R8 flags at done");
    @(negedge clk);
    own = o; cur = s0; pll_ack = a0; start = 1;
    for (int k = 1; k <= g + 2; k++) begin
      @(negedge clk);
      if (k == 1) begin
        start = 0;
        check(busy == 1'b1, "R2 busy after start", busy, 1);
        check({warn, ack_to, rst_to} == 3'b000, "R9 flags cleared on start",
              {warn, ack_to, rst_to}, 0);
      end
      if (extra && k == 2) start = 1;
      if (extra && k == 3) start = 0;
      if (k == s_at) cur = 2'b11;
      if (k == a_at) pll_ack = 1'b0;
    end
    @(negedge clk);
    check(busy == 1'b0, "R2 idle after done", busy, 0);
    check(exp_q.size() == 0, "R4 all actions seen", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({busy, done, clr, prst, req_clr, vf_zero, gate, mac_rst} == 0, "R1 reset outputs",
          {busy, done, clr, prst, req_clr, vf_zero, gate, mac_rst}, 0);
    check({rst_to, ack_to, warn} == 0, "R1 reset flags", {rst_to, ack_to, warn}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0, "R1 idle after reset", busy, 0);
    run(2'b11, 2'b11, 0, 1'b0, 0, 0);       // R3 both lanes, immediate
    run(2'b01, 2'b01, 0, 1'b0, 0, 0);       // R5 lane 1 not owned, its status low
    run(2'b10, 2'b00, 7, 1'b1, 14, 0);      // R3 lane 0 only, R5/R7 mid-wait exits
    run(2'b11, 2'b01, 0, 1'b1, 0, 0);       // R6 R7 both timeouts
    repeat (5) @(negedge clk);
    check({warn, ack_to, rst_to} == 3'b111, "R9 flags sticky while idle",
          {warn, ack_to, rst_to}, 7);
    run(2'b11, 2'b11, 0, 1'b0, 0, 1);       // R10 extra start while busy, R9 cleared
    run(2'b11, 2'b00, 0, 1'b0, 0, 0);       // R6 only reset timeout
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule